// File: doc/BRIEF.md
# Sorted Block Half-Merge Unit

The unit joins two blocks of K values that are each already in non-decreasing order. One block belongs to a lower-ranked partner and the other to a higher-ranked partner. It returns two new blocks of K values. The lower result holds the K smallest values of the 2K inputs, and the upper result holds the K largest. Each result is in non-decreasing order. The merged list of 2K values is never stored as a whole.

A start pulse, taken while the unit is idle, copies both input blocks into internal registers. In every busy cycle a forward merge takes the smaller of the two heads and writes the next lower-result slot. A backward merge takes the larger of the two tails and writes the next upper-result slot, working down from the top. After K cycles both results are complete, and a one-cycle done pulse marks them valid. The results then hold until a later operation overwrites them. K and the element width are parameters.

Top module: `pair_split_merge`

## Requirements
- R1: A start pulse taken while idle loads both input blocks, and busy is high on the next cycle. Element i of every block port sits at bits [i*W +: W], with element 0 the first and smallest.
- R2: When done is high, the lower result holds the K smallest input values in non-decreasing order, and its last element is no greater than the first element of the upper result.
- R3: When done is high, the upper result holds the K largest input values in non-decreasing order.
- R4: With repeated values, including values shared between the two blocks, the two results together hold exactly the multiset of the 2K inputs.
- R5: With K = 1 the unit is a compare-exchange: the lower result is the minimum of the two inputs and the upper result is the maximum.
- R6: Done is a single-cycle pulse. It rises on the K-th clock edge after the edge that took the start, and busy is low while done is high.
- R7: A start raised while busy is ignored: neither the stored blocks nor the results of the running operation change.
- R8: A synchronous active-high reset clears busy, done and both results to zero. An operation cut short by reset produces no done.
- R9: While idle, both results hold their values, even when the input block ports change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only while idle |
| lo_blk_i | input | K*W | Sorted block from the lower-ranked partner |
| hi_blk_i | input | K*W | Sorted block from the higher-ranked partner |
| lo_res_o | output | K*W | K smallest values, non-decreasing |
| hi_res_o | output | K*W | K largest values, non-decreasing |
| done_o | output | 1 | One-cycle pulse: results complete |
| busy_o | output | 1 | Operation in progress |

## Verification
The assertions check on every cycle the properties that hold for any data:
- both results are sorted at done, and the lower block sits below the upper one;
- done is a single-cycle pulse at exactly K cycles after an accepted start;
- the stored blocks stay frozen while busy;
- the results stay still while idle;
- reset clears the control state.

Only the bench scenarios can show that the results are the right values. They cover the exact multiset of the union when values repeat across the blocks, the K = 1 compare-exchange, and the worked five-element example. They also show that a start raised in the middle of an operation is ignored, by leaving the first operation's outcome intact.

// File: rtl/hm_pkg.sv
package hm_pkg;

    typedef enum logic {
        HM_IDLE = 1'b0,
        HM_RUN  = 1'b1
    } hm_state_e;

endpackage

// File: rtl/hm_pick.sv
// Chooses one of two candidate values for a merge step.
// TAKE_LARGER = 0: forward merge, smaller head wins, tie goes to block A.
// TAKE_LARGER = 1: backward merge, larger tail wins, tie goes to block B.
module hm_pick #(
    parameter int W           = 16,
    parameter bit TAKE_LARGER = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         take_a_o,
    output logic [W-1:0] val_o
);

    generate
        if (TAKE_LARGER) begin : g_large
            always_comb begin
                take_a_o = (a_i > b_i);
            end
        end else begin : g_small
            always_comb begin
                take_a_o = (a_i <= b_i);
            end
        end
    endgenerate

    always_comb begin
        val_o = take_a_o ? a_i : b_i;
    end

endmodule

// File: rtl/hm_ctrl.sv
// Sequencer: idle/run state, step index and done pulse.
module hm_ctrl #(
    parameter int K = 8
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          start_i,
    output logic                          accept_o,
    output logic                          busy_o,
    output logic [((K > 1) ? $clog2(K) : 1)-1:0] step_o,
    output logic                          done_o
);

    localparam int IW = (K > 1) ? $clog2(K) : 1;
    localparam logic [IW-1:0] LAST = IW'(K - 1);

    typedef struct packed {
        hm_pkg::hm_state_e st;
        logic [IW-1:0]     step;
        logic              done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        accept_o = 1'b0;
        unique case (c_q.st)
            hm_pkg::HM_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    c_d.st   = hm_pkg::HM_RUN;
                    c_d.step = '0;
                end
            end
            hm_pkg::HM_RUN: begin
                if (c_q.step == LAST) begin
                    c_d.st   = hm_pkg::HM_IDLE;
                    c_d.done = 1'b1;
                    c_d.step = '0;
                end else begin
                    c_d.step = c_q.step + IW'(1);
                end
            end
            default: c_d.st = hm_pkg::HM_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            c_q <= '{st: hm_pkg::HM_IDLE, step: '0, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o = (c_q.st == hm_pkg::HM_RUN);
    assign step_o = c_q.step;
    assign done_o = c_q.done;

endmodule

// File: rtl/pair_split_merge.sv
// Merges two sorted K-element blocks and keeps the low half for the lower
// partner and the high half for the upper partner, one element of each per cycle.
module pair_split_merge #(
    parameter int K = 8,
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         start_i,
    input  logic [K*W-1:0] lo_blk_i,
    input  logic [K*W-1:0] hi_blk_i,
    output logic [K*W-1:0] lo_res_o,
    output logic [K*W-1:0] hi_res_o,
    output logic         done_o,
    output logic         busy_o
);

    localparam int IW = (K > 1) ? $clog2(K) : 1;
    localparam logic [IW-1:0] LAST = IW'(K - 1);

    typedef struct packed {
        logic [K-1:0][W-1:0] blk_a;   // lower-ranked block
        logic [K-1:0][W-1:0] blk_b;   // higher-ranked block
        logic [K-1:0][W-1:0] res_lo;
        logic [K-1:0][W-1:0] res_hi;
        logic [IW-1:0]       head_a;  // forward pointers
        logic [IW-1:0]       head_b;
        logic [IW-1:0]       used_a;  // elements consumed from the tails
        logic [IW-1:0]       used_b;
    } dp_t;

    dp_t r_d, r_q;

    logic          accept;
    logic          busy;
    logic [IW-1:0] step;
    logic          done;

    logic [W-1:0]  fwd_a, fwd_b, fwd_v;
    logic [W-1:0]  bwd_a, bwd_b, bwd_v;
    logic          fwd_take_a, bwd_take_a;

    logic [K*W-1:0] held_lo_blk;
    logic [K*W-1:0] held_hi_blk;

    hm_ctrl #(.K(K)) u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy),
        .step_o   (step),
        .done_o   (done)
    );

    // Within K steps neither pointer can run past its block, since at most
    // step+1 <= K elements have been taken from the two blocks together.
    always_comb begin
        fwd_a = r_q.blk_a[r_q.head_a];
        fwd_b = r_q.blk_b[r_q.head_b];
        bwd_a = r_q.blk_a[LAST - r_q.used_a];
        bwd_b = r_q.blk_b[LAST - r_q.used_b];
    end

    hm_pick #(.W(W), .TAKE_LARGER(1'b0)) u_fwd (
        .a_i      (fwd_a),
        .b_i      (fwd_b),
        .take_a_o (fwd_take_a),
        .val_o    (fwd_v)
    );

    hm_pick #(.W(W), .TAKE_LARGER(1'b1)) u_bwd (
        .a_i      (bwd_a),
        .b_i      (bwd_b),
        .take_a_o (bwd_take_a),
        .val_o    (bwd_v)
    );

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.blk_a  = lo_blk_i;
            r_d.blk_b  = hi_blk_i;
            r_d.head_a = '0;
            r_d.head_b = '0;
            r_d.used_a = '0;
            r_d.used_b = '0;
        end
        if (busy) begin
            r_d.res_lo[step]        = fwd_v;
            r_d.res_hi[LAST - step] = bwd_v;
            if (fwd_take_a) begin
                r_d.head_a = r_q.head_a + IW'(1);
            end else begin
                r_d.head_b = r_q.head_b + IW'(1);
            end
            if (bwd_take_a) begin
                r_d.used_a = r_q.used_a + IW'(1);
            end else begin
                r_d.used_b = r_q.used_b + IW'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign held_lo_blk = r_q.blk_a;
    assign held_hi_blk = r_q.blk_b;
    assign lo_res_o    = r_q.res_lo;
    assign hi_res_o    = r_q.res_hi;
    assign done_o      = done;
    assign busy_o      = busy;

endmodule

// File: rtl/hm_chk.sv
module hm_chk #(
    parameter int K = 8,
    parameter int W = 16
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic           start_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [K*W-1:0] lo_res_o,
    input logic [K*W-1:0] hi_res_o,
    input logic [K*W-1:0] held_lo_blk,
    input logic [K*W-1:0] held_hi_blk
);

    function automatic bit ordered(input logic [K*W-1:0] v);
        bit ok = 1'b1;
        for (int i = 1; i < K; i++) begin
            if (v[i*W +: W] < v[(i-1)*W +: W]) ok = 1'b0;
        end
        return ok;
    endfunction

    int unsigned since_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            since_q <= 0;
        end else if (start_i && !busy_o) begin
            since_q <= 0;
        end else if (busy_o) begin
            since_q <= since_q + 1;
        end
    end

    assert_accept_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !busy_o) |=> busy_o);

    assert_lo_sorted_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> ordered(lo_res_o));

    assert_split_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (lo_res_o[(K-1)*W +: W] <= hi_res_o[0 +: W]));

    assert_hi_sorted_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> ordered(hi_res_o));

    assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !busy_o);

    assert_done_latency_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (since_q == K));

    assert_hold_blocks_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |=> ($stable(held_lo_blk) && $stable(held_hi_blk)));

    assert_reset_clear_R8: assert property (@(posedge clk_i)
        rst_i |=> (!busy_o && !done_o));

    assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |=> ($stable(lo_res_o) && $stable(hi_res_o)));

endmodule

bind pair_split_merge hm_chk #(.K(K), .W(W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .lo_res_o    (lo_res_o),
    .hi_res_o    (hi_res_o),
    .held_lo_blk (held_lo_blk),
    .held_hi_blk (held_hi_blk)
);

// File: tb/sim_pair_split_merge.sv
`timescale 1ns/1ps
module sim_pair_split_merge;

    localparam int K = 8;
    localparam int W = 16;
    typedef logic [K*W-1:0] blk_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int nchecks = 0;
    int nerr    = 0;

    // main instance
    logic s0_start = 1'b0;
    blk_t s0_a = '0, s0_b = '0, s0_lo, s0_hi;
    logic s0_done, s0_busy;

    pair_split_merge #(.K(K), .W(W)) u0 (
        .clk_i(clk), .rst_i(rst), .start_i(s0_start),
        .lo_blk_i(s0_a), .hi_blk_i(s0_b),
        .lo_res_o(s0_lo), .hi_res_o(s0_hi),
        .done_o(s0_done), .busy_o(s0_busy)
    );

    // single-element instance
    logic s1_start = 1'b0;
    logic [15:0] s1_a = '0, s1_b = '0, s1_lo, s1_hi;
    logic s1_done, s1_busy;

    pair_split_merge #(.K(1), .W(16)) u1 (
        .clk_i(clk), .rst_i(rst), .start_i(s1_start),
        .lo_blk_i(s1_a), .hi_blk_i(s1_b),
        .lo_res_o(s1_lo), .hi_res_o(s1_hi),
        .done_o(s1_done), .busy_o(s1_busy)
    );

    // five-element instance
    logic s5_start = 1'b0;
    logic [39:0] s5_a = '0, s5_b = '0, s5_lo, s5_hi;
    logic s5_done, s5_busy;

    pair_split_merge #(.K(5), .W(8)) u5 (
        .clk_i(clk), .rst_i(rst), .start_i(s5_start),
        .lo_blk_i(s5_a), .hi_blk_i(s5_b),
        .lo_res_o(s5_lo), .hi_res_o(s5_hi),
        .done_o(s5_done), .busy_o(s5_busy)
    );

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model(input blk_t pa, input blk_t pb,
                                  output blk_t elo, output blk_t ehi);
        logic [W-1:0] u [2*K];
        logic [W-1:0] t;
        for (int i = 0; i < K; i++) begin
            u[i]     = pa[i*W +: W];
            u[K + i] = pb[i*W +: W];
        end
        for (int i = 1; i < 2*K; i++) begin
            for (int j = i; j > 0; j--) begin
                if (u[j] < u[j-1]) begin
                    t = u[j]; u[j] = u[j-1]; u[j-1] = t;
                end
            end
        end
        elo = '0;
        ehi = '0;
        for (int i = 0; i < K; i++) begin
            elo[i*W +: W] = u[i];
            ehi[i*W +: W] = u[K + i];
        end
    endfunction

    function automatic blk_t rand_blk(input int unsigned range);
        logic [W-1:0] v [K];
        logic [W-1:0] t;
        blk_t r;
        for (int i = 0; i < K; i++) v[i] = W'($urandom % range);
        for (int i = 1; i < K; i++) begin
            for (int j = i; j > 0; j--) begin
                if (v[j] < v[j-1]) begin
                    t = v[j]; v[j] = v[j-1]; v[j-1] = t;
                end
            end
        end
        r = '0;
        for (int i = 0; i < K; i++) r[i*W +: W] = v[i];
        return r;
    endfunction

    task automatic run0(input blk_t pa, input blk_t pb, input bit inject);
        blk_t elo, ehi;
        int cyc;
        bit seen;
        model(pa, pb, elo, ehi);
        @(negedge clk);
        s0_a = pa; s0_b = pb; s0_start = 1'b1;
        @(negedge clk);
        s0_start = 1'b0;
        cyc = 1;
        check(s0_busy == 1'b1, "R1 busy after start", 128'(s0_busy), 128'(1));
        seen = 1'b0;
        while (!seen && cyc < 4*K + 8) begin
            if (inject && cyc == 3) begin
                s0_a = ~pa; s0_b = ~pb; s0_start = 1'b1;   // R7 stimulus
            end else begin
                s0_start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (s0_done) seen = 1'b1;
        end
        s0_start = 1'b0;
        check(seen && cyc == K + 1, "R6 done latency", 128'(cyc), 128'(K + 1));
        check(s0_busy == 1'b0, "R6 busy low at done", 128'(s0_busy), 128'(0));
        check(s0_lo == elo, inject ? "R7 R2 lower result" : "R2 R4 lower result",
              s0_lo, elo);
        check(s0_hi == ehi, inject ? "R7 R3 upper result" : "R3 R4 upper result",
              s0_hi, ehi);
        @(negedge clk);
        check(s0_done == 1'b0, "R6 done single cycle", 128'(s0_done), 128'(0));
    endtask

    task automatic run1(input logic [15:0] pa, input logic [15:0] pb);
        int cyc;
        logic [15:0] emin, emax;
        emin = (pa < pb) ? pa : pb;
        emax = (pa < pb) ? pb : pa;
        @(negedge clk);
        s1_a = pa; s1_b = pb; s1_start = 1'b1;
        @(negedge clk);
        s1_start = 1'b0;
        cyc = 1;
        while (!s1_done && cyc < 10) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 2, "R5 R6 single-element latency", 128'(cyc), 128'(2));
        check(s1_lo == emin, "R5 minimum", 128'(s1_lo), 128'(emin));
        check(s1_hi == emax, "R5 maximum", 128'(s1_hi), 128'(emax));
    endtask

    blk_t d_lo, d_hi, keep_lo, keep_hi;
    bit   saw;

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: state after reset
        check(s0_busy == 1'b0 && s0_done == 1'b0, "R8 idle after reset",
              128'({s0_busy, s0_done}), 128'(0));
        check(s0_lo == '0 && s0_hi == '0, "R8 results cleared",
              {s0_lo[63:0], s0_hi[63:0]}, 128'(0));

        // directed cases for u0
        d_lo = '0; d_hi = '0;
        for (int i = 0; i < K; i++) begin
            d_lo[i*W +: W] = W'(i);
            d_hi[i*W +: W] = W'(100 + i);
        end
        run0(d_lo, d_hi, 1'b0);              // lower block entirely smaller
        run0(d_hi, d_lo, 1'b0);              // upper block entirely smaller
        for (int i = 0; i < K; i++) begin
            d_lo[i*W +: W] = 16'd7;
            d_hi[i*W +: W] = 16'd7;
        end
        run0(d_lo, d_hi, 1'b0);              // R4 all values equal
        for (int i = 0; i < K; i++) begin
            d_lo[i*W +: W] = W'(2*i);
            d_hi[i*W +: W] = W'(2*i + 1);
        end
        run0(d_lo, d_hi, 1'b0);              // interleaved
        for (int i = 0; i < K; i++) begin
            d_lo[i*W +: W] = W'(i / 2);
            d_hi[i*W +: W] = W'(i / 3 + 1);
        end
        run0(d_lo, d_hi, 1'b0);              // R4 ties across blocks
        run0(rand_blk(65536), rand_blk(65536), 1'b1);   // R7 start while busy

        // constrained random: narrow range forces duplicates (R4)
        for (int n = 0; n < 40; n++) begin
            run0(rand_blk((n % 2 == 0) ? 6 : 65536),
                 rand_blk((n % 3 == 0) ? 6 : 65536), 1'b0);
        end

        // R9: results hold while idle and inputs change
        keep_lo = s0_lo; keep_hi = s0_hi;
        s0_a = rand_blk(65536); s0_b = rand_blk(65536);
        repeat (5) @(negedge clk);
        check(s0_lo == keep_lo, "R9 lower result held", s0_lo, keep_lo);
        check(s0_hi == keep_hi, "R9 upper result held", s0_hi, keep_hi);

        // R8: reset in the middle of an operation
        @(negedge clk);
        s0_start = 1'b1;
        @(negedge clk);
        s0_start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(s0_busy == 1'b0 && s0_done == 1'b0, "R8 reset aborts operation",
              128'({s0_busy, s0_done}), 128'(0));
        check(s0_lo == '0 && s0_hi == '0, "R8 reset clears results",
              {s0_lo[63:0], s0_hi[63:0]}, 128'(0));
        saw = 1'b0;
        repeat (K + 3) begin
            @(negedge clk);
            if (s0_done) saw = 1'b1;
        end
        check(saw == 1'b0, "R8 no done after abort", 128'(saw), 128'(0));

        // R5: single-element compare-exchange
        run1(16'd5, 16'd3);
        run1(16'd2, 16'd9);
        run1(16'd7, 16'd7);

        // five-element worked example, element 0 in the low byte (R2, R3)
        @(negedge clk);
        s5_a = 40'h0D_0B_08_06_01;
        s5_b = 40'h0C_0A_09_07_02;
        s5_start = 1'b1;
        @(negedge clk);
        s5_start = 1'b0;
        repeat (10) begin
            if (!s5_done) @(negedge clk);
        end
        check(s5_done == 1'b1, "R6 example done", 128'(s5_done), 128'(1));
        check(s5_lo == 40'h08_07_06_02_01, "R2 example lower",
              128'(s5_lo), 128'(40'h08_07_06_02_01));
        check(s5_hi == 40'h0D_0C_0B_0A_09, "R3 example upper",
              128'(s5_hi), 128'(40'h0D_0C_0B_0A_09));

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchecks++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule